// File: doc/BRIEF.md
# Accumulator Rounding Unit

This block rounds a 36-bit fixed-point accumulator word in one registered step. The word is split into three parts: a 4-bit guard extension in bits 35–32, a 16-bit high word in bits 31–16 and a 16-bit low word in bits 15–0. The rounded value keeps the extension and the high word, and the low word is cleared. A mode input selects the rounding rule. Mode 0 is round-half-to-even, also called convergent rounding. Mode 1 is plain two's-complement round-half-up.

Beside the value, the block produces five condition flags. These are negative (N), zero (Z), extension-in-use (E), unnormalized (U) and overflow (V). A width-select input makes N and Z look at the low 32 bits only, instead of the full 36. An operand is accepted when its strobe is high. The result and flags appear after the next clock edge, together with a one-cycle valid pulse.

Top module: `acc_rnd_unit`

## Requirements
- R1: Every output result has bits 15–0 equal to zero. Bits 35–16 hold the rounded extension and high word.
- R2: When `rnd_mode` is 1 (two's-complement), the result is the operand plus 0x8000, taken modulo 2^36, with bits 15–0 then cleared.
- R3: When `rnd_mode` is 0 (convergent) and bits 15–0 of the operand are not exactly 0x8000, the result is the same as in R2.
- R4: When `rnd_mode` is 0 and bits 15–0 of the operand equal 0x8000, bit 16 of the sum is forced to 0. For example, 0x0_1236_8000 gives 0x0_1236_0000, 0x0_1235_8000 gives 0x0_1236_0000, and 0x5_1236_789A gives 0x5_1236_0000.
- R5: When `flag_w32` is 0, N equals result bit 35 and Z is 1 exactly when all 36 result bits are zero.
- R6: When `flag_w32` is 1, N equals result bit 31 and Z is 1 exactly when result bits 31–0 are zero. E, U and V are not affected by `flag_w32`.
- R7: E is 1 when result bits 35–31 are not all equal.
- R8: U is 1 when result bit 31 equals result bit 30.
- R9: V is 1 when operand bit 35 is 0 and result bit 35 is 1.
- R10: An operand presented with `in_valid` high at a rising edge drives `out_valid` high for exactly the next cycle. Without `in_valid`, `out_valid` is low and the result and flags hold their previous values.
- R11: A synchronous active-high `rst` clears `out_valid`, the result and all flags to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| in_acc | input | 36 | Operand: extension, high word and low word |
| rnd_mode | input | 1 | 0 = convergent, 1 = two's-complement |
| flag_w32 | input | 1 | 1 = N and Z use bits 31–0 only |
| out_valid | output | 1 | One-cycle result strobe |
| out_acc | output | 36 | Rounded result, low word zero |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_e | output | 1 | Extension-in-use flag |
| out_u | output | 1 | Unnormalized flag |
| out_v | output | 1 | Overflow flag |

## Verification
A wrong tie decision shows in the result strobed one cycle after the operand. It appears as an odd bit 16 on a 0x8000 low word, and only in mode 0. A wrong carry or overflow computation shows at the same time, either as a high word that is off by one or as a V that disagrees with the sign change from operand to result. Since the block keeps no state beyond one output register, any error surfaces in the cycle right after the strobe. An output register that fails to hold shows on the first idle cycle, as a changed value while `out_valid` is low.

// File: rtl/acc_rnd_pkg.sv
package acc_rnd_pkg;

  typedef enum logic {
    RND_CONV = 1'b0,
    RND_TWOS = 1'b1
  } rnd_mode_e;

  typedef struct packed {
    logic n;
    logic z;
    logic e;
    logic u;
    logic v;
  } rnd_flags_t;

endpackage

// File: rtl/acc_rnd_core.sv
module acc_rnd_core
  import acc_rnd_pkg::*;
#(
  parameter int EXT_W = 4,
  parameter int HI_W  = 16,
  parameter int LO_W  = 16
) (
  input  logic [EXT_W+HI_W+LO_W-1:0] acc_i,
  input  rnd_mode_e                  mode_i,
  output logic [EXT_W+HI_W+LO_W-1:0] rounded_o,
  output logic                       tie_o,
  output logic                       ovf_o
);
  localparam int ACC_W = EXT_W + HI_W + LO_W;
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (LO_W - 1);

  function automatic logic [ACC_W-1:0] add_half(input logic [ACC_W-1:0] a);
    return a + HALF;
  endfunction

  function automatic logic is_tie(input logic [ACC_W-1:0] a);
    return a[LO_W-1:0] == HALF[LO_W-1:0];
  endfunction

  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] kept;

  always_comb begin
    sum   = add_half(acc_i);
    tie_o = (mode_i == RND_CONV) && is_tie(acc_i);
    kept  = sum;
    if (tie_o) kept[LO_W] = 1'b0;
    kept[LO_W-1:0] = '0;
    rounded_o = kept;
    ovf_o = !acc_i[ACC_W-1] && sum[ACC_W-1];
  end
endmodule

// File: rtl/acc_rnd_flags.sv
module acc_rnd_flags
  import acc_rnd_pkg::*;
#(
  parameter int EXT_W = 4,
  parameter int HI_W  = 16,
  parameter int LO_W  = 16
) (
  input  logic [EXT_W+HI_W+LO_W-1:0] res_i,
  input  logic                       w32_i,
  input  logic                       ovf_i,
  output rnd_flags_t                 flags_o
);
  localparam int ACC_W  = EXT_W + HI_W + LO_W;
  localparam int NARROW = HI_W + LO_W;
  localparam int TOP    = NARROW - 1;

  function automatic logic guard_used(input logic [ACC_W-1:0] r);
    logic [EXT_W:0] g;
    g = r[ACC_W-1:TOP];
    return !((g == '0) || (g == '1));
  endfunction

  always_comb begin
    flags_o.n = w32_i ? res_i[TOP] : res_i[ACC_W-1];
    flags_o.z = w32_i ? (res_i[NARROW-1:0] == '0) : (res_i == '0);
    flags_o.e = guard_used(res_i);
    flags_o.u = res_i[TOP] == res_i[TOP-1];
    flags_o.v = ovf_i;
  end
endmodule

// File: rtl/acc_rnd_oreg.sv
module acc_rnd_oreg
  import acc_rnd_pkg::*;
#(
  parameter int ACC_W = 36
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [ACC_W-1:0] res_i,
  input  rnd_flags_t       flags_i,
  output logic             valid_o,
  output logic [ACC_W-1:0] res_o,
  output rnd_flags_t       flags_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      flags_o <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) begin
        res_o   <= res_i;
        flags_o <= flags_i;
      end
    end
  end
endmodule

// File: rtl/acc_rnd_unit.sv
module acc_rnd_unit
  import acc_rnd_pkg::*;
#(
  parameter int EXT_W = 4,
  parameter int HI_W  = 16,
  parameter int LO_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [EXT_W+HI_W+LO_W-1:0] in_acc,
  input  logic                       rnd_mode,
  input  logic                       flag_w32,
  output logic                       out_valid,
  output logic [EXT_W+HI_W+LO_W-1:0] out_acc,
  output logic                       out_n,
  output logic                       out_z,
  output logic                       out_e,
  output logic                       out_u,
  output logic                       out_v
);
  localparam int ACC_W = EXT_W + HI_W + LO_W;

  logic [ACC_W-1:0] rounded;
  logic             tie_hit;
  logic             add_ovf;
  rnd_flags_t       next_flags;
  rnd_flags_t       held_flags;
  rnd_mode_e        mode_sel;

  assign mode_sel = rnd_mode_e'(rnd_mode);

  acc_rnd_core #(.EXT_W(EXT_W), .HI_W(HI_W), .LO_W(LO_W)) u_core (
    .acc_i     (in_acc),
    .mode_i    (mode_sel),
    .rounded_o (rounded),
    .tie_o     (tie_hit),
    .ovf_o     (add_ovf)
  );

  acc_rnd_flags #(.EXT_W(EXT_W), .HI_W(HI_W), .LO_W(LO_W)) u_flags (
    .res_i   (rounded),
    .w32_i   (flag_w32),
    .ovf_i   (add_ovf),
    .flags_o (next_flags)
  );

  acc_rnd_oreg #(.ACC_W(ACC_W)) u_oreg (
    .clk     (clk),
    .rst     (rst),
    .load_i  (in_valid),
    .res_i   (rounded),
    .flags_i (next_flags),
    .valid_o (out_valid),
    .res_o   (out_acc),
    .flags_o (held_flags)
  );

  assign out_n = held_flags.n;
  assign out_z = held_flags.z;
  assign out_e = held_flags.e;
  assign out_u = held_flags.u;
  assign out_v = held_flags.v;
endmodule

// File: rtl/acc_rnd_unit_chk.sv
module acc_rnd_unit_chk #(
  parameter int EXT_W = 4,
  parameter int HI_W  = 16,
  parameter int LO_W  = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       in_valid,
  input logic [EXT_W+HI_W+LO_W-1:0] in_acc,
  input logic                       rnd_mode,
  input logic                       tie_hit,
  input logic                       out_valid,
  input logic [EXT_W+HI_W+LO_W-1:0] out_acc,
  input logic                       out_n,
  input logic                       out_z,
  input logic                       out_v
);
  localparam int ACC_W = EXT_W + HI_W + LO_W;
  localparam int HW    = EXT_W + HI_W;

  assert_lsp_zero_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_acc[LO_W-1:0] == '0);

  assert_twos_step_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rnd_mode) |=>
      out_acc[ACC_W-1:LO_W] == HW'($past(in_acc[ACC_W-1:LO_W]) + HW'($past(in_acc[LO_W-1]))));

  assert_tie_even_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && tie_hit) |=> !out_acc[LO_W]);

  assert_zn_excl_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_z) |-> !out_n);

  assert_ovf_sign_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_v) |-> out_acc[ACC_W-1]);

  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_acc));
endmodule

bind acc_rnd_unit acc_rnd_unit_chk #(.EXT_W(EXT_W), .HI_W(HI_W), .LO_W(LO_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_acc    (in_acc),
  .rnd_mode  (rnd_mode),
  .tie_hit   (tie_hit),
  .out_valid (out_valid),
  .out_acc   (out_acc),
  .out_n     (out_n),
  .out_z     (out_z),
  .out_v     (out_v)
);

// File: tb/acc_rnd_unit_bench.sv
module acc_rnd_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [35:0] in_acc = '0;
  logic        rnd_mode = 1'b0;
  logic        flag_w32 = 1'b0;
  logic        out_valid;
  logic [35:0] out_acc;
  logic        out_n, out_z, out_e, out_u, out_v;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  acc_rnd_unit u_acc_rnd_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_acc(in_acc),
    .rnd_mode(rnd_mode), .flag_w32(flag_w32), .out_valid(out_valid),
    .out_acc(out_acc), .out_n(out_n), .out_z(out_z), .out_e(out_e),
    .out_u(out_u), .out_v(out_v)
  );

  function automatic longint ref_round(input longint a, input bit mode);
    longint s;
    s = (a + 64'h8000) % 64'h10_0000_0000;
    if (!mode && (a % 64'h1_0000) == 64'h8000)
      s = s & ~longint'(64'h1_0000);
    return (s / 64'h1_0000) * 64'h1_0000;
  endfunction

  // expected flag vector {n,z,e,u,v}
  function automatic logic [4:0] ref_flags(input longint a, input longint r, input bit w32);
    longint top5, lo32;
    logic n, z, e, u, v;
    lo32 = r % 64'h1_0000_0000;
    top5 = r / 64'h8000_0000;
    n = w32 ? (lo32 >= 64'h8000_0000) : (r >= 64'h8_0000_0000);
    z = w32 ? (lo32 == 0) : (r == 0);
    e = (top5 != 0) && (top5 != 31);
    u = (((top5 % 2) == 1) == ((lo32 / 64'h4000_0000) % 2 == 1));
    v = (a < 64'h8_0000_0000) && (r >= 64'h8_0000_0000);
    return {n, z, e, u, v};
  endfunction

  task automatic compare(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [35:0] a, input bit mode, input bit w32);
    longint r;
    @(negedge clk);
    in_acc = a; rnd_mode = mode; flag_w32 = w32; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    r = ref_round(longint'(a), mode);
    compare({tag, " valid R10"}, 64'(out_valid), 64'd1);
    compare({tag, " value"}, 64'(out_acc), 64'(r));
    compare({tag, " flags R5 R6 R7 R8 R9"},
            64'({out_n, out_z, out_e, out_u, out_v}),
            64'(ref_flags(longint'(a), r, w32)));
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [35:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    compare("R11 reset valid", 64'(out_valid), 64'd0);
    compare("R11 reset value", 64'(out_acc), 64'd0);
    compare("R11 reset flags", 64'({out_n, out_z, out_e, out_u, out_v}), 64'd0);
    rst = 1'b0;

    apply("R3 R1 case 5_1236_789A", 36'h5_1236_789A, 1'b0, 1'b0);
    compare("R3 literal", 64'(out_acc), 64'h5_1236_0000);
    apply("R4 tie even", 36'h0_1236_8000, 1'b0, 1'b0);
    compare("R4 literal even", 64'(out_acc), 64'h0_1236_0000);
    apply("R4 tie odd", 36'h0_1235_8000, 1'b0, 1'b0);
    compare("R4 literal odd", 64'(out_acc), 64'h0_1236_0000);
    apply("R2 tie twos", 36'h0_1236_8000, 1'b1, 1'b0);
    compare("R2 literal", 64'(out_acc), 64'h0_1237_0000);
    apply("R9 overflow", 36'h7_FFFF_8000, 1'b1, 1'b0);
    compare("R9 v flag", 64'(out_v), 64'd1);
    compare("R7 e flag", 64'(out_e), 64'd1);
    apply("R2 wrap to zero", 36'hF_FFFF_8000, 1'b1, 1'b0);
    compare("R5 z flag", 64'(out_z), 64'd1);
    apply("R4 wrap tie", 36'hF_FFFF_8000, 1'b0, 1'b0);
    apply("R6 narrow zero", 36'h1_0000_0000, 1'b0, 1'b1);
    compare("R6 z narrow", 64'(out_z), 64'd1);
    apply("R5 wide nonzero", 36'h1_0000_0000, 1'b0, 1'b0);
    compare("R5 z wide", 64'(out_z), 64'd0);
    apply("R6 narrow neg", 36'h0_8000_1234, 1'b1, 1'b1);
    compare("R6 n narrow", 64'(out_n), 64'd1);
    apply("R8 normalized", 36'h0_4000_0000, 1'b0, 1'b0);
    compare("R8 u flag", 64'(out_u), 64'd0);

    held = out_acc;
    @(negedge clk);
    compare("R10 idle valid", 64'(out_valid), 64'd0);
    compare("R10 idle hold", 64'(out_acc), 64'(held));

    for (int i = 0; i < 3000; i++) begin
      logic [35:0] a;
      a = {4'($urandom()), $urandom()};
      case ($urandom() % 4)
        0: a[15:0] = 16'h8000;
        1: a[15:0] = 16'h7FFF;
        default: ;
      endcase
      apply("R2 R3 R4 random", a, 1'($urandom()), 1'($urandom()));
    end

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    compare("R11 late reset", 64'({out_valid, out_acc}), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule